// File: doc/BRIEF.md
# Half-Period Pulse Stretcher

This block turns a narrow, periodic trigger pulse into a square wave with roughly 50% duty cycle at the same frequency. Each output high phase starts on a rising edge of the trigger. A slower instrument can therefore latch a signal that would otherwise be too short for it. The trigger arrives without any relation to the system clock. It first passes through a two-stage synchronizer, and its rising edges are turned into one-cycle events.

A counter measures the interval between consecutive trigger rises in system clock cycles. At each rise that closes an interval, the block halves the count with a one-bit right shift. It then drives the output high for that many cycles, starting on the same event.

Because the high time always comes from the interval that has just completed, the duty cycle follows trigger frequency changes with a lag of one period. If the trigger stops for longer than the counter can hold, the counter saturates. The block then drops its output and its lock flag and waits for a fresh measurement. The counter width is derived from the system clock frequency and the lowest trigger frequency. At the defaults (60 MHz clock, 2 Hz trigger) this gives 25 bits.

Top module: `half_period_stretcher`

## Requirements
- R1: While reset is asserted, and right after it is released, `pulse_out` and `lock_ok` are both 0.
- R2: The first trigger rise after reset, or after a loss of lock, produces no output and leaves `lock_ok` at 0. `lock_ok` becomes 1 at the rise that closes the first measured interval. `pulse_out` is never 1 while `lock_ok` is 0.
- R3: The interval is the number of clock cycles between two detected trigger rises. The following high phase of `pulse_out` lasts floor(interval/2) cycles, so an odd interval rounds down (21 cycles gives 10).
- R4: When `trig_in` rises between two clock edges, `pulse_out` is 1 after the third following clock edge. This is 2 cycles after the edge that first samples the trigger high.
- R5: A trigger that stays high for only 3 clock cycles is detected. Each rise produces exactly one single-cycle internal event, and intervals as short as 5 cycles are measured correctly.
- R6: A change in trigger period first shows in the high time of the phase that follows the first interval completed at the new period. The phase that starts at the first rise of the new period still uses the old half-period.
- R7: A trigger rise that arrives while `pulse_out` is still high restarts the high phase with the new half-period. The remainder of the old high phase is not completed first.
- R8: If the interval counter reaches its maximum, 2^W-1 where W is the counter width, before the next rise, `lock_ok` and `pulse_out` go to 0. After that, one new rise does not restore lock. A second rise does, and it yields a new high phase.
- R9: The interval counter is W = clog2(CLK_HZ/MIN_TRIG_HZ + 1) bits wide (25 at the defaults). While measuring, it advances by exactly one per cycle and never wraps around.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all counts are in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_in | input | 1 | Narrow trigger pulse, asynchronous to `clk` |
| pulse_out | output | 1 | Regenerated half-period square wave |
| lock_ok | output | 1 | A valid interval measurement is in use |

## Verification
The assertions check the following on every cycle:
- each detected rise is a single-cycle event;
- the interval counter advances by one without wrapping;
- a closed interval sets the lock flag and saturation clears it;
- an accepted rise raises the output and a reload loads the new half-period;
- the output is never high without lock.

Only the bench scenarios can show the end-to-end results. These are the exact high-phase lengths for even, odd and very short periods, the two-cycle latency from a sampled rise, and the one-period lag after a frequency change. They also include the merged high phase when a faster rise reloads the timer, and the two-rise recovery after the counter saturates.

// File: rtl/hps_pkg.sv
package hps_pkg;

  // Events handed from the interval meter to the output timer.
  typedef struct packed {
    logic fire;   // a rise closed a valid interval
    logic drop;   // the interval counter saturated
  } hps_evt_t;

  // Bits needed to count the longest interval without wrapping.
  function automatic int count_bits(input int clk_hz, input int min_hz);
    return $clog2(clk_hz / min_hz + 1);
  endfunction

endpackage

// File: rtl/hps_edge_detect.sv
module hps_edge_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  // sh[SYNC_STAGES-1] is the synchronized level; sh[SYNC_STAGES] is its delay.
  logic [SYNC_STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[SYNC_STAGES-1:0], async_in};
  end

  assign rise = sh[SYNC_STAGES-1] & ~sh[SYNC_STAGES];

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise); // R5

endmodule

// File: rtl/hps_period_meter.sv
module hps_period_meter
  import hps_pkg::*;
#(
  parameter int CNT_W = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise,
  output hps_evt_t         evt,
  output logic [CNT_W-1:0] half_len,
  output logic             locked
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  function automatic logic [CNT_W-1:0] half_of(input logic [CNT_W-1:0] c);
    return c >> 1;
  endfunction

  logic             armed;
  logic [CNT_W-1:0] cnt;
  logic             at_max;

  assign at_max   = (cnt == CNT_MAX);
  assign evt.fire = rise & armed & ~at_max;
  assign evt.drop = armed & at_max;
  assign half_len = half_of(cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed  <= 1'b0;
      cnt    <= '0;
      locked <= 1'b0;
    end else if (rise) begin
      armed  <= 1'b1;
      cnt    <= CNT_ONE;
      locked <= evt.fire;
    end else if (evt.drop) begin
      armed  <= 1'b0;
      locked <= 1'b0;
    end else if (armed) begin
      cnt <= cnt + CNT_ONE;
    end
  end

  AST_DONE_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    evt.fire |=> locked); // R2
  AST_SAT_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    evt.drop |=> !locked); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !rise && !at_max) |=> (cnt == $past(cnt) + CNT_ONE)); // R9
  AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> (cnt == CNT_ONE)); // R3

endmodule

// File: rtl/hps_high_gen.sv
module hps_high_gen
  import hps_pkg::*;
#(
  parameter int CNT_W = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  hps_evt_t         evt,
  input  logic [CNT_W-1:0] half_len,
  output logic             pulse_out
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] hrem;
  logic             load;

  assign load = evt.fire & (half_len != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_out <= 1'b0;
      hrem      <= '0;
    end else if (evt.drop) begin
      pulse_out <= 1'b0;
      hrem      <= '0;
    end else if (load) begin
      pulse_out <= 1'b1;
      hrem      <= half_len;
    end else if (pulse_out) begin
      if (hrem == CNT_ONE) begin
        pulse_out <= 1'b0;
        hrem      <= '0;
      end else begin
        hrem <= hrem - CNT_ONE;
      end
    end
  end

  AST_FIRE_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> pulse_out); // R4
  AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_out && load) |=> (hrem == $past(half_len))); // R7
  AST_DROP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    evt.drop |=> !pulse_out); // R8
  AST_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_out && hrem > CNT_ONE && !evt.drop) |=> pulse_out); // R3

endmodule

// File: rtl/half_period_stretcher.sv
module half_period_stretcher
  import hps_pkg::*;
#(
  parameter int CLK_HZ      = 60_000_000,
  parameter int MIN_TRIG_HZ = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_in,
  output logic pulse_out,
  output logic lock_ok
);
  localparam int CNT_W = count_bits(CLK_HZ, MIN_TRIG_HZ);

  // Internal events brought out as named wires.
  logic             rise_evt;
  hps_evt_t         meter_evt;
  logic [CNT_W-1:0] half_len;

  hps_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (trig_in),
    .rise     (rise_evt)
  );

  hps_period_meter #(.CNT_W(CNT_W)) u_meter (
    .clk      (clk),
    .rst_n    (rst_n),
    .rise     (rise_evt),
    .evt      (meter_evt),
    .half_len (half_len),
    .locked   (lock_ok)
  );

  hps_high_gen #(.CNT_W(CNT_W)) u_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt       (meter_evt),
    .half_len  (half_len),
    .pulse_out (pulse_out)
  );

  AST_OUT_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_out |-> lock_ok); // R2

endmodule

// File: tb/tb_half_period_stretcher.sv
`timescale 1ns/1ps
module tb_half_period_stretcher;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig_in = 1'b0;
  logic pulse_out, lock_ok;

  // Small counter (10 bits, max 1023) so saturation is reachable.
  half_period_stretcher #(.CLK_HZ(1000), .MIN_TRIG_HZ(1), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in),
    .pulse_out(pulse_out), .lock_ok(lock_ok)
  );

  always #2 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;

  // Output monitor, sampling 1 ns after each rising edge.
  int cyc = 0;
  logic trig_prev = 1'b0, out_prev = 1'b0;
  int trig_rise_cyc = 0, out_rise_cyc = 0;
  int highs[$];
  int lats[$];

  always @(posedge clk) begin
    #1;
    cyc++;
    if (trig_in && !trig_prev) trig_rise_cyc = cyc;
    if (pulse_out && !out_prev) begin
      out_rise_cyc = cyc;
      lats.push_back(cyc - trig_rise_cyc);
    end
    if (!pulse_out && out_prev) highs.push_back(cyc - out_rise_cyc);
    trig_prev = trig_in;
    out_prev  = pulse_out;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    trig_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    highs.delete();
    lats.delete();
  endtask

  // Called at a negedge; rises are spaced exactly 'period' cycles apart.
  task automatic pulse_train(input int period, input int count);
    for (int i = 0; i < count; i++) begin
      trig_in = 1'b1;
      repeat (3) @(negedge clk);
      trig_in = 1'b0;
      repeat (period - 3) @(negedge clk);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    trig_in = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 pulse_out in reset", int'(pulse_out), 0);
    chk("R1 lock_ok in reset", int'(lock_ok), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 pulse_out after reset", int'(pulse_out), 0);
    chk("R1 lock_ok after reset", int'(lock_ok), 0);
  endtask

  task automatic t_first_edge();
    do_reset();
    pulse_train(20, 1);
    idle(30);
    chk("R2 no lock after one rise", int'(lock_ok), 0);
    chk("R2 no output after one rise", highs.size() + lats.size(), 0);
    pulse_train(20, 1);
    chk("R2 lock after second rise", int'(lock_ok), 1);
    idle(30);
    chk("R2 one high phase", highs.size(), 1);
    if (highs.size() == 1) chk("R3 high of 50-cycle interval", highs[0], 25);
  endtask

  task automatic t_steady();
    do_reset();
    pulse_train(20, 5);
    idle(30);
    chk("R3 high phase count", highs.size(), 4);
    foreach (highs[i]) chk("R3 high of 20-cycle interval", highs[i], 10);
    foreach (lats[i]) chk("R4 rise latency", lats[i], 2);
  endtask

  task automatic t_odd_and_narrow();
    do_reset();
    pulse_train(21, 3);
    idle(20);
    chk("R3 odd count", highs.size(), 2);
    foreach (highs[i]) chk("R3 odd interval rounds down", highs[i], 10);
    do_reset();
    pulse_train(5, 4);
    idle(10);
    chk("R5 short-period phase count", highs.size(), 3);
    foreach (highs[i]) chk("R5 high of 5-cycle interval", highs[i], 2);
    foreach (lats[i]) chk("R5 latency at short period", lats[i], 2);
  endtask

  task automatic t_freq_change();
    do_reset();
    pulse_train(20, 5);
    pulse_train(40, 3);
    pulse_train(10, 2);
    idle(20);
    chk("R6 phase count", highs.size(), 8);
    if (highs.size() == 8) begin
      chk("R6 first rise of new period keeps old half", highs[4], 10);
      chk("R6 new half one period later", highs[5], 20);
      chk("R6 steady at new period", highs[6], 20);
      chk("R7 reload merges 10 + 5", highs[7], 15);
    end
  endtask

  task automatic t_saturate();
    do_reset();
    pulse_train(20, 3);
    chk("R8 locked before stall", int'(lock_ok), 1);
    idle(1100);
    chk("R8 lock cleared on saturation", int'(lock_ok), 0);
    chk("R8 output low on saturation", int'(pulse_out), 0);
    chk("R8 phases before stall", highs.size(), 2);
    pulse_train(30, 1);
    chk("R8 one rise does not relock", int'(lock_ok), 0);
    chk("R8 no output after one rise", highs.size(), 2);
    pulse_train(30, 1);
    chk("R8 second rise relocks", int'(lock_ok), 1);
    idle(25);
    chk("R8 new phase after recovery", highs.size(), 3);
    if (highs.size() == 3) chk("R9 fresh measurement high", highs[2], 15);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_first_edge();
    t_steady();
    t_odd_and_narrow();
    t_freq_change();
    t_saturate();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule